// File: doc/BRIEF.md
# Two-Dimensional Window Burst Address Generator

This block converts a request for a rectangular pixel window into a stream of memory read requests. Every request covers one whole atomic unit, and its base address is aligned to that unit. A motion-compensation or filter engine gives the window's left edge and top line, its width and height in bytes, the frame's start address and the line pitch. The block then walks the window line by line, and left to right within each line. A line segment that starts or ends inside a unit is widened to the enclosing unit boundaries, because a burst is never cut short.

The frame is stored with its lines spread over the memory banks. Line `L` lives in bank `L mod NBANKS`, and inside that bank it is line `L div NBANKS`, placed at `frame_base + (L div NBANKS) * line_pitch`. As a result, each step from one line to the next moves to a different bank. Every emitted request carries its bank, its linear in-bank address and that address split into row and column. A signed counter reports bytes fetched minus bytes asked for, so the cost of misalignment and of the burst-length choice can be measured.

Top module: `burst2d_fetch`

## Requirements
- R1: While or after `rst_n` is low at a clock edge, `bst_valid` is 0, `req_ready` is 1 and `over_bytes` is 0. A reset in the middle of a window abandons it.
- R2: The unit size is `BL * BUS_BYTES` bytes. `bl_code` 0 selects BL2, 1 selects BL4 and 2 selects BL8. Code 3 behaves as BL8. With the default 4-byte bus this gives 8, 16 and 32 bytes.
- R3: For each line the block emits unit indices `floor(x/U)` through `floor((x+w-1)/U)` in ascending order, with exactly one request per index. Width and height are taken to be at least 1.
- R4: Lines are emitted in order from `y` to `y+h-1`, and all units of one line come before any unit of the next line.
- R5: `bst_bank` equals the low `log2(NBANKS)` bits of the absolute line number. After the last unit of a line, the next request's bank is one higher, modulo NBANKS.
- R6: `bst_addr = frame_base + (line div NBANKS) * line_pitch + unit_index * U`. `bst_row` is `bst_addr` bits [AW-1:COL_BITS] and `bst_col` is bits [COL_BITS-1:0], where COL_BITS defaults to 10.
- R7: `bst_last` is 1 only on the final request of the window. After that request is taken, `bst_valid` drops and `req_ready` returns to 1 on the next cycle.
- R8: While `bst_valid` is 1 and `bst_ready` is 0, every `bst_*` output holds its value.
- R9: Accepting a request clears `over_bytes`. Once a line's last request is taken, the counter equals the unit bytes fetched so far minus `w` times the lines finished, and it is never negative at that point. Examples: an 8×21 window at BL8 ends at 504 when aligned and 1176 when it straddles a unit. At BL4 the same window ends at 168 when aligned and 504 in the worst case.
- R10: `req_ready` is 0 while a window is in progress. A request offered then is ignored and does not change the requests that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bl_code | input | 2 | Burst length select, sampled when a request is accepted |
| req_valid | input | 1 | Window request offered |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_x | input | XW (12) | Left byte position of the window |
| req_y | input | YW (12) | Top line of the window |
| req_w | input | WW (8) | Window width in bytes |
| req_h | input | HW (8) | Window height in lines |
| frame_base | input | AW (32) | In-bank start address of the frame |
| line_pitch | input | AW (32) | Byte distance between two lines of the same bank |
| bst_valid | output | 1 | A burst request is presented |
| bst_ready | input | 1 | Consumer takes the burst request |
| bst_addr | output | AW (32) | Aligned in-bank burst address |
| bst_bank | output | log2(NBANKS) (2) | Bank of the burst |
| bst_row | output | AW-COL_BITS (22) | Row part of the address |
| bst_col | output | COL_BITS (10) | Column part of the address |
| bst_last | output | 1 | Final burst of the window |
| over_bytes | output | WW+HW+2 (18) | Signed count of bytes fetched minus bytes requested |

## Verification
When a line's segment spans a single unit, one handshake does three things at once: it closes the line, it subtracts the requested width and adds a whole unit to the over-fetch counter, and it moves the bank to the next line's. Windows one unit wide, both aligned and unaligned, provoke this on every request. They are judged by the expected request sequence and by the final counter. The line-end bank step can also coincide with a consumer stall. A repeating `bst_ready` pattern places stalls on line-end requests, and the bench checks that the held request does not change before it is finally taken.

// File: rtl/burst2d_pkg.sv
// Shared types for the 2-D window burst generator.
// Assumes nothing beyond a single clock domain.
package burst2d_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } burst2d_state_t;

    localparam int SHIFT_W = 5;
endpackage

// File: rtl/burst2d_span.sv
// Works out the unit size shift and the first and last unit index covered
// by one line segment [x, x+w-1].
// Assumes w >= 1. Code 3 of bl_code is treated as BL8.
module burst2d_span #(
    parameter int XW        = 12,
    parameter int WW        = 8,
    parameter int BUS_BYTES = 4
) (
    input  logic [1:0]                       bl_code,
    input  logic [XW-1:0]                    x,
    input  logic [WW-1:0]                    w,
    output logic [burst2d_pkg::SHIFT_W-1:0]  ushift,
    output logic [XW:0]                      first_unit,
    output logic [XW:0]                      last_unit
);
    localparam int BUS_LOG = $clog2(BUS_BYTES);

    logic [XW:0] end_byte;

    // Map the burst code to log2 of the unit size and locate the segment's units.
    always_comb begin
        case (bl_code)
            2'd0:    ushift = burst2d_pkg::SHIFT_W'(BUS_LOG + 1);
            2'd1:    ushift = burst2d_pkg::SHIFT_W'(BUS_LOG + 2);
            default: ushift = burst2d_pkg::SHIFT_W'(BUS_LOG + 3);
        endcase
        end_byte   = {1'b0, x} + (XW+1)'(w) - (XW+1)'(1);
        first_unit = {1'b0, x} >> ushift;
        last_unit  = end_byte >> ushift;
    end
endmodule

// File: rtl/burst2d_map.sv
// Bank-interleaved address mapping. The absolute line picks the bank from
// its low bits, and its remaining bits select the line inside that bank.
// Assumes NBANKS is a power of two, at least 2.
module burst2d_map #(
    parameter int AW       = 32,
    parameter int LW       = 13,
    parameter int UW       = 13,
    parameter int NBANKS   = 4,
    parameter int COL_BITS = 10
) (
    input  logic [AW-1:0]                    frame_base,
    input  logic [AW-1:0]                    line_pitch,
    input  logic [LW-1:0]                    line_abs,
    input  logic [UW-1:0]                    unit_idx,
    input  logic [burst2d_pkg::SHIFT_W-1:0]  ushift,
    output logic [AW-1:0]                    addr,
    output logic [$clog2(NBANKS)-1:0]        bank,
    output logic [AW-COL_BITS-1:0]           row,
    output logic [COL_BITS-1:0]              col
);
    localparam int BKB = $clog2(NBANKS);

    logic [AW-1:0] line_in_bank;
    logic [AW-1:0] line_off;
    logic [AW-1:0] unit_off;

    // Form the in-bank address and split it into bank, row and column.
    always_comb begin
        line_in_bank = AW'(line_abs >> BKB);
        line_off     = line_in_bank * line_pitch;
        unit_off     = AW'(unit_idx) << ushift;
        addr         = frame_base + line_off + unit_off;
        bank         = line_abs[BKB-1:0];
        row          = addr[AW-1:COL_BITS];
        col          = addr[COL_BITS-1:0];
    end
endmodule

// File: rtl/burst2d_fetch.sv
// Top of the 2-D window burst generator. Takes one window request, then
// emits aligned whole-unit read requests line by line, left to right,
// with a running over-fetch count. Assumes req_w and req_h are at least 1,
// req_h does not exceed the line range, and frame_base and line_pitch are
// unit aligned.
module burst2d_fetch #(
    parameter int AW        = 32,
    parameter int XW        = 12,
    parameter int YW        = 12,
    parameter int WW        = 8,
    parameter int HW        = 8,
    parameter int BUS_BYTES = 4,
    parameter int NBANKS    = 4,
    parameter int COL_BITS  = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    bl_code,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [XW-1:0]                 req_x,
    input  logic [YW-1:0]                 req_y,
    input  logic [WW-1:0]                 req_w,
    input  logic [HW-1:0]                 req_h,
    input  logic [AW-1:0]                 frame_base,
    input  logic [AW-1:0]                 line_pitch,
    output logic                          bst_valid,
    input  logic                          bst_ready,
    output logic [AW-1:0]                 bst_addr,
    output logic [$clog2(NBANKS)-1:0]     bst_bank,
    output logic [AW-COL_BITS-1:0]        bst_row,
    output logic [COL_BITS-1:0]           bst_col,
    output logic                          bst_last,
    output logic signed [WW+HW+1:0]       over_bytes
);
    import burst2d_pkg::*;

    localparam int BKB = $clog2(NBANKS);
    localparam int UW  = XW + 1;
    localparam int LW  = YW + 1;
    localparam int OW  = WW + HW + 2;

    burst2d_state_t        st_q;
    logic [SHIFT_W-1:0]    ushift_q;
    logic [UW-1:0]         first_q, last_q, cur_q;
    logic [WW-1:0]         w_q;
    logic [HW-1:0]         hm1_q, line_q;
    logic [YW-1:0]         y_q;
    logic [AW-1:0]         base_q, pitch_q;
    logic signed [OW-1:0]  ovf_q;

    logic [SHIFT_W-1:0]    span_shift;
    logic [UW-1:0]         span_first, span_last;
    logic [LW-1:0]         line_abs;
    logic                  accept, take, line_end;
    logic signed [OW-1:0]  ovf_step;

    burst2d_span #(.XW(XW), .WW(WW), .BUS_BYTES(BUS_BYTES)) u_span (
        .bl_code    (bl_code),
        .x          (req_x),
        .w          (req_w),
        .ushift     (span_shift),
        .first_unit (span_first),
        .last_unit  (span_last)
    );

    burst2d_map #(.AW(AW), .LW(LW), .UW(UW), .NBANKS(NBANKS), .COL_BITS(COL_BITS)) u_map (
        .frame_base (base_q),
        .line_pitch (pitch_q),
        .line_abs   (line_abs),
        .unit_idx   (cur_q),
        .ushift     (ushift_q),
        .addr       (bst_addr),
        .bank       (bst_bank),
        .row        (bst_row),
        .col        (bst_col)
    );

    // Handshake decode, position flags and the over-fetch increment.
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        bst_valid = (st_q == ST_RUN);
        accept    = req_valid && req_ready;
        take      = bst_valid && bst_ready;
        line_end  = (cur_q == last_q);
        bst_last  = bst_valid && line_end && (line_q == hm1_q);
        line_abs  = {1'b0, y_q} + LW'(line_q);
        ovf_step  = (OW'(1) << ushift_q) - ((cur_q == first_q) ? OW'(w_q) : OW'(0));
        over_bytes = ovf_q;
    end

    // Window walker: latch the request, then step the unit and line counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            ushift_q <= '0;
            first_q  <= '0;
            last_q   <= '0;
            cur_q    <= '0;
            w_q      <= '0;
            hm1_q    <= '0;
            line_q   <= '0;
            y_q      <= '0;
            base_q   <= '0;
            pitch_q  <= '0;
            ovf_q    <= '0;
        end else if (accept) begin
            st_q     <= ST_RUN;
            ushift_q <= span_shift;
            first_q  <= span_first;
            last_q   <= span_last;
            cur_q    <= span_first;
            w_q      <= req_w;
            hm1_q    <= req_h - HW'(1);
            line_q   <= '0;
            y_q      <= req_y;
            base_q   <= frame_base;
            pitch_q  <= line_pitch;
            ovf_q    <= '0;
        end else if (take) begin
            ovf_q <= ovf_q + ovf_step;
            if (!line_end) begin
                cur_q <= cur_q + UW'(1);
            end else if (line_q == hm1_q) begin
                st_q <= ST_IDLE;
            end else begin
                cur_q  <= first_q;
                line_q <= line_q + HW'(1);
            end
        end
    end

    // Held request must not change under back-pressure.
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_addr) && $stable(bst_bank) && $stable(bst_last)));

    // Taking the final request returns the block to idle.
    p_last_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && bst_ready && bst_last) |=> (!bst_valid && req_ready));

    // Crossing a line boundary steps to the next bank.
    p_bank_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && line_end && !bst_last) |=> (bst_bank == BKB'($past(bst_bank) + 1'b1)));

    // Inside a line the bank stays put.
    p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !line_end) |=> $stable(bst_bank));

    // Accepted request blocks further requests.
    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!req_ready && bst_valid && over_bytes == 0));

    // After a full line the over-fetch count is never negative.
    p_ovf_nonneg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && line_end) |=> (over_bytes >= 0));
endmodule

// File: tb/burst2d_fetch_test.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module burst2d_fetch_test;
    localparam int AW = 32;

    typedef struct packed {
        logic [31:0] bl;
        logic [31:0] x;
        logic [31:0] y;
        logic [31:0] w;
        logic [31:0] h;
        logic [31:0] nb;
        logic [31:0] ov;
    } vec_t;

    // bl, x, y, w, h, expected burst count, expected final over-fetch
    localparam vec_t VECS [7] = '{
        '{32'd2, 32'd0,   32'd0, 32'd8,  32'd21, 32'd21, 32'd504},
        '{32'd2, 32'd28,  32'd3, 32'd8,  32'd21, 32'd42, 32'd1176},
        '{32'd1, 32'd0,   32'd0, 32'd8,  32'd21, 32'd21, 32'd168},
        '{32'd1, 32'd12,  32'd5, 32'd8,  32'd21, 32'd42, 32'd504},
        '{32'd0, 32'd5,   32'd6, 32'd20, 32'd3,  32'd12, 32'd36},
        '{32'd3, 32'd100, 32'd1, 32'd1,  32'd2,  32'd2,  32'd62},
        '{32'd0, 32'd3,   32'd2, 32'd2,  32'd6,  32'd6,  32'd36}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bl_code = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_x = '0;
    logic [11:0] req_y = '0;
    logic [7:0]  req_w = '0;
    logic [7:0]  req_h = '0;
    logic [31:0] frame_base = 32'h0001_0000;
    logic [31:0] line_pitch = 32'h0000_0200;
    logic        bst_valid;
    logic        bst_ready = 1'b0;
    logic [31:0] bst_addr;
    logic [1:0]  bst_bank;
    logic [21:0] bst_row;
    logic [9:0]  bst_col;
    logic        bst_last;
    logic signed [17:0] over_bytes;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    burst2d_fetch uut (
        .clk(clk), .rst_n(rst_n), .bl_code(bl_code),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h),
        .frame_base(frame_base), .line_pitch(line_pitch),
        .bst_valid(bst_valid), .bst_ready(bst_ready),
        .bst_addr(bst_addr), .bst_bank(bst_bank), .bst_row(bst_row),
        .bst_col(bst_col), .bst_last(bst_last), .over_bytes(over_bytes)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int unit_bytes(input logic [31:0] bl);
        return (bl == 0) ? 8 : (bl == 1) ? 16 : 32;
    endfunction

    // Offer a request at a falling edge; it is taken at the next rising edge.
    task automatic issue(input vec_t v);
        @(negedge clk);
        bl_code = v.bl[1:0];
        req_x = v.x[11:0]; req_y = v.y[11:0];
        req_w = v.w[7:0];  req_h = v.h[7:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Collect and check every burst of one window; optionally poke a request mid-run.
    task automatic run_window(input vec_t v, input bit poke);
        int u_sz, ufirst, ulast, ei, eu, n, cyc;
        bit done, held;
        logic [31:0] h_addr;
        logic [1:0]  h_bank;
        logic        h_last;
        longint ea;
        u_sz = unit_bytes(v.bl);
        ufirst = int'(v.x) / u_sz;
        ulast  = (int'(v.x) + int'(v.w) - 1) / u_sz;
        ei = 0; eu = ufirst; n = 0; cyc = 0; done = 0; held = 0;
        h_addr = '0; h_bank = '0; h_last = 1'b0;
        issue(v);
        while (!done && cyc < 5000) begin
            if (cyc != 0) @(negedge clk);
            bst_ready = ((cyc % 3) != 1);
            #1;
            if (poke && cyc == 2) begin
                check(req_ready == 1'b0, "R10 busy ready", req_ready, 0);
                req_x = 12'd500; req_y = 12'd77; req_w = 8'd40; req_h = 8'd9;
                bl_code = 2'd0;
                req_valid = 1'b1;
            end
            if (bst_valid) begin
                if (held) begin
                    check(bst_addr == h_addr && bst_bank == h_bank && bst_last == h_last,
                          "R8 hold", bst_addr, h_addr);
                end
                if (bst_ready) begin
                    ea = longint'(frame_base) + longint'((int'(v.y) + ei) / 4) * longint'(line_pitch)
                         + longint'(eu) * longint'(u_sz);
                    check(bst_addr == 32'(ea), "R3 R4 R6 address", bst_addr, ea);
                    check(bst_bank == 2'((int'(v.y) + ei) % 4), "R5 bank", bst_bank, (int'(v.y) + ei) % 4);
                    check(bst_row == 22'(ea >> 10) && bst_col == 10'(ea), "R6 row col", {bst_row, bst_col}, ea);
                    check(bst_last == (ei == int'(v.h) - 1 && eu == ulast), "R7 last", bst_last,
                          (ei == int'(v.h) - 1 && eu == ulast));
                    n++;
                    if (eu == ulast) begin
                        eu = ufirst;
                        ei++;
                        if (ei == int'(v.h)) begin
                            done = 1;
                            req_valid = 1'b0;
                        end
                    end else begin
                        eu++;
                    end
                    held = 0;
                end else begin
                    held = 1;
                    h_addr = bst_addr; h_bank = bst_bank; h_last = bst_last;
                end
            end
            cyc++;
        end
        req_valid = 1'b0;
        check(done, "R3 window completes", done, 1);
        @(negedge clk);
        #1;
        check(!bst_valid && req_ready, "R7 idle after last", bst_valid, 0);
        check(n == int'(v.nb), "R3 burst count (R2 unit size)", n, v.nb);
        check(over_bytes == 18'(v.ov), "R9 over-fetch", over_bytes, v.ov);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!bst_valid && req_ready && over_bytes == 0, "R1 reset state", bst_valid, 0);
        rst_n = 1'b1;

        for (int k = 0; k < 7; k++) begin
            run_window(VECS[k], 1'b0);
        end

        // R10: a request offered mid-window is ignored.
        run_window(VECS[4], 1'b1);

        // R1: reset in the middle of a window abandons it.
        issue(VECS[0]);
        bst_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(!bst_valid && req_ready && over_bytes == 0, "R1 mid-run reset", bst_valid, 0);
        rst_n = 1'b1;

        // After reset a fresh window runs normally.
        run_window(VECS[5], 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule